// File: doc/BRIEF.md
# I2C Channel Select Controller

This block is a bus target that decides which of four downstream bus segments are joined to the upstream bus. A controller on the upstream bus writes a one-byte control word, and the low four bits of that word become four channel-enable outputs that steer external pass switches. Any mix of channels may be on at once, including none or all four. The same byte can be read back at any time.

The target address is formed from a fixed three-bit prefix and two strap inputs. Each strap carries a 2-bit level code, so the two straps give sixteen addresses. A general-call software reset, an external active-low reset and power-on reset each turn every channel off. A device-identification query returns three fixed bytes. The serial clock and data lines arrive as sampled inputs. They pass through a two-flop synchronizer and a short glitch filter before any edge or START/STOP is decoded. The data line is driven open-drain through an output enable. Bus clock rates up to 1 MHz are supported as long as the system clock oversamples them.

Top module: `chan_select_switch`

## Requirements
- R1: Control byte bits [3:0] drive chanEn[3:0] (bit n enables channel n). Any of the sixteen subsets is allowed. Bits [7:4] are dropped on write and read back as zero.
- R2: A written byte reaches chanEn only on the STOP that follows it. If a transfer writes several data bytes, the last one wins. A repeated START before the STOP discards the pending byte, and chanEn keeps its old value.
- R3: A read transfer to the block's own address returns {4'b0000, chanEn} in every data byte.
- R4: While hwRstN is low, chanEn is 0 and sdaOe is 0, even in the middle of a transfer or an ACK. After hwRstN is released, the block answers a new transfer normally.
- R5: chanEn is 0 during and after porRstN, and it makes no pulse before the first write.
- R6: The block's 7-bit address is {3'b101, strapHi, strapLo}. The block ACKs only that address, or one of the special addresses in R7 and R8. It NACKs every other address.
- R7: A general-call address byte 0x00 is ACKed. A following data byte 0x06 is ACKed and clears chanEn at once. Any other data byte after the general call is NACKed and changes nothing.
- R8: Identification sequence. The write byte 0xF8 is ACKed. A following byte equal to {own address, 1'b0} is ACKed, and any other byte is NACKed. Next comes a repeated START and the byte 0xF9. That byte is ACKed only if the previous step succeeded. The block then returns 0x3C, 0x51 and 0x07, and returns 0xFF for any byte after those three.
- R9: sdaOe is high only while the block ACKs or sends a 0 data bit. It is low at idle, while the controller sends, and when the block sends a 1 bit.
- R10: A level change on SCL or SDA that lasts fewer than FILT_LEN (3) system clocks is ignored. For example, a one-clock SDA high pulse while SCL is high is not taken as a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| hwRstN | input | 1 | External reset, active low, asynchronous |
| strapLo | input | 2 | Low address strap level code |
| strapHi | input | 2 | High address strap level code |
| sclIn | input | 1 | Sampled serial clock line |
| sdaIn | input | 1 | Sampled serial data line |
| sdaOe | output | 1 | Pull the data line low when 1 |
| chanEn | output | 4 | Channel enables, bit n for channel n |

## Verification
The bench writes every enable pattern with junk in the upper nibble. It checks that chanEn still holds the old value just before the STOP, which catches a design that applies a write on the data ACK instead of on the STOP, or that keeps the upper bits. It sweeps all sixteen strap codes and sends a neighbouring address to each, so a swapped strap or a loose compare shows up as a wrong ACK or a wrong NACK. It aborts a write with a repeated START, and it injects a one-clock SDA pulse that looks like a STOP; a design that commits on either one changes chanEn. It also asserts the external reset during an ACK, and it runs the identification query both armed and unarmed, which exposes an SDA left driven low or an ID byte read out of turn.

// File: rtl/chan_select_pkg.sv
package chan_select_pkg;

  localparam logic [7:0] GEN_CALL_BYTE = 8'h00;
  localparam logic [7:0] SW_RESET_CMD  = 8'h06;
  localparam logic [7:0] ID_QUERY_WR   = 8'hF8;
  localparam logic [7:0] ID_QUERY_RD   = 8'hF9;

  typedef enum logic [2:0] {
    SRC_REG, SRC_ID0, SRC_ID1, SRC_ID2, SRC_FILL
  } txSrc_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   pendSet;
    logic   pendClr;
    logic   commit;
    logic   swReset;
    logic   txLoad;
    logic   txBit;
    logic   ackDrv;
    logic   sdaRel;
    txSrc_e txSrc;
  } strobe_t;

  // datapath -> control bus events
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sclFall;
    logic sdaBit;
  } busEv_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RXB, ST_ACKW, ST_TXB, ST_ACKR, ST_SKIP
  } state_e;

  typedef enum logic [2:0] {
    MD_ADDR, MD_WR, MD_RD, MD_GC, MD_IDARG, MD_IDRD, MD_SINK
  } mode_e;

endpackage

// File: rtl/chan_select_dp.sv
module chan_select_dp
  import chan_select_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int FILT_LEN = 3,
  parameter logic [7:0] ID_BYTE0 = 8'h3C,
  parameter logic [7:0] ID_BYTE1 = 8'h51,
  parameter logic [7:0] ID_BYTE2 = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  strobe_t           stb,
  output busEv_t            ev,
  output logic [7:0]        rxByte,
  output logic              sdaOe,
  output logic [NUM_CH-1:0] chanEn
);

  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam int LINES = 2;

  logic [LINES-1:0] rawIn, syncA, syncB, filt;
  logic             sclQ, sdaQ;
  logic [7:0]       rxShift, txShift, srcByte, regByte;
  logic [NUM_CH-1:0] pend;
  logic             pendValid;

  assign rawIn = {sdaIn, sclIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1;
      syncB <= '1;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  // per-line glitch filter: a new level must persist FILT_LEN samples
  for (genvar i = 0; i < LINES; i++) begin : g_filt
    logic             lvl;
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lvl <= 1'b1;
        cnt <= '0;
      end else if (syncB[i] == lvl) begin
        cnt <= '0;
      end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
        lvl <= syncB[i];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign filt[i] = lvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= filt[0];
      sdaQ <= filt[1];
    end
  end

  assign ev.sclRise = filt[0] & ~sclQ;
  assign ev.sclFall = ~filt[0] & sclQ;
  assign ev.startEv = filt[0] & sclQ & sdaQ & ~filt[1];
  assign ev.stopEv  = filt[0] & sclQ & ~sdaQ & filt[1];
  assign ev.sdaBit  = filt[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxShift <= '0;
    else if (ev.sclRise) rxShift <= {rxShift[6:0], filt[1]};
  end
  assign rxByte = rxShift;

  always_comb begin
    regByte = '0;
    regByte[NUM_CH-1:0] = chanEn;
  end

  always_comb begin
    case (stb.txSrc)
      SRC_REG: srcByte = regByte;
      SRC_ID0: srcByte = ID_BYTE0;
      SRC_ID1: srcByte = ID_BYTE1;
      SRC_ID2: srcByte = ID_BYTE2;
      default: srcByte = 8'hFF;
    endcase
  end

  // open-drain data driver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaOe   <= 1'b0;
      txShift <= '1;
    end else if (stb.txLoad) begin
      sdaOe   <= ~srcByte[7];
      txShift <= {srcByte[6:0], 1'b1};
    end else if (stb.txBit) begin
      sdaOe   <= ~txShift[7];
      txShift <= {txShift[6:0], 1'b1};
    end else if (stb.ackDrv) begin
      sdaOe   <= 1'b1;
    end else if (stb.sdaRel) begin
      sdaOe   <= 1'b0;
    end
  end

  // control register with staged write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanEn    <= '0;
      pend      <= '0;
      pendValid <= 1'b0;
    end else if (stb.swReset) begin
      chanEn    <= '0;
      pendValid <= 1'b0;
    end else if (stb.commit) begin
      if (pendValid) chanEn <= pend;
      pendValid <= 1'b0;
    end else if (stb.pendClr) begin
      pendValid <= 1'b0;
    end else if (stb.pendSet) begin
      pend      <= rxShift[NUM_CH-1:0];
      pendValid <= 1'b1;
    end
  end

  assert_sw_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.swReset |=> chanEn == '0);

  assert_en_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanEn) |-> $past(stb.commit || stb.swReset));

  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    ev.startEv |=> !sdaOe);

endmodule

// File: rtl/chan_select_fsm.sv
module chan_select_fsm
  import chan_select_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEv_t     ev,
  input  logic [7:0] rxByte,
  input  logic [6:0] ownAddr,
  output strobe_t    stb
);

  state_e     state, stateN;
  mode_e      mode, modeN, nextMode;
  logic [3:0] bitCnt, cntN;
  logic       idArmed, armN;
  logic [1:0] idIdx, idxN;
  logic       mAck, mAckN;
  logic       ackIt;

  function automatic txSrc_e pickSrc(mode_e m, logic [1:0] idx);
    if (m == MD_RD) return SRC_REG;
    case (idx)
      2'd0:    return SRC_ID0;
      2'd1:    return SRC_ID1;
      2'd2:    return SRC_ID2;
      default: return SRC_FILL;
    endcase
  endfunction

  always_comb begin
    stb      = '0;
    stb.txSrc = SRC_REG;
    stateN   = state;
    modeN    = mode;
    cntN     = bitCnt;
    armN     = idArmed;
    idxN     = idIdx;
    mAckN    = mAck;
    ackIt    = 1'b0;
    nextMode = mode;
    if (ev.stopEv) begin
      stateN     = ST_IDLE;
      stb.commit = 1'b1;
      stb.sdaRel = 1'b1;
      armN       = 1'b0;
    end else if (ev.startEv) begin
      stateN      = ST_RXB;
      modeN       = MD_ADDR;
      cntN        = '0;
      stb.pendClr = 1'b1;
      stb.sdaRel  = 1'b1;
    end else begin
      case (state)
        ST_RXB: begin
          if (ev.sclRise) begin
            cntN = bitCnt + 4'd1;
          end else if (ev.sclFall && bitCnt == 4'd8) begin
            case (mode)
              MD_ADDR: begin
                if (rxByte[7:1] == ownAddr) begin
                  ackIt    = 1'b1;
                  nextMode = rxByte[0] ? MD_RD : MD_WR;
                end else if (rxByte == GEN_CALL_BYTE) begin
                  ackIt    = 1'b1;
                  nextMode = MD_GC;
                end else if (rxByte == ID_QUERY_WR) begin
                  ackIt    = 1'b1;
                  nextMode = MD_IDARG;
                end else if (rxByte == ID_QUERY_RD && idArmed) begin
                  ackIt    = 1'b1;
                  nextMode = MD_IDRD;
                  armN     = 1'b0;
                  idxN     = '0;
                end
              end
              MD_WR: begin
                ackIt       = 1'b1;
                stb.pendSet = 1'b1;
              end
              MD_GC: begin
                if (rxByte == SW_RESET_CMD) begin
                  ackIt       = 1'b1;
                  stb.swReset = 1'b1;
                end
              end
              MD_IDARG: begin
                if (rxByte == {ownAddr, 1'b0}) begin
                  ackIt    = 1'b1;
                  armN     = 1'b1;
                  nextMode = MD_SINK;
                end
              end
              default: ackIt = 1'b0;
            endcase
            if (ackIt) begin
              stb.ackDrv = 1'b1;
              stateN     = ST_ACKW;
              modeN      = nextMode;
            end else begin
              stateN = ST_SKIP;
            end
          end
        end
        ST_ACKW: begin
          if (ev.sclFall) begin
            if (mode == MD_RD || mode == MD_IDRD) begin
              stb.txLoad = 1'b1;
              stb.txSrc  = pickSrc(mode, idIdx);
              if (mode == MD_IDRD && idIdx != 2'd3) idxN = idIdx + 2'd1;
              cntN   = 4'd1;
              stateN = ST_TXB;
            end else begin
              stb.sdaRel = 1'b1;
              cntN       = '0;
              stateN     = ST_RXB;
            end
          end
        end
        ST_TXB: begin
          if (ev.sclFall) begin
            if (bitCnt == 4'd8) begin
              stb.sdaRel = 1'b1;
              stateN     = ST_ACKR;
            end else begin
              stb.txBit = 1'b1;
              cntN      = bitCnt + 4'd1;
            end
          end
        end
        ST_ACKR: begin
          if (ev.sclRise) begin
            mAckN = ~ev.sdaBit;
          end else if (ev.sclFall) begin
            if (mAck) begin
              stb.txLoad = 1'b1;
              stb.txSrc  = pickSrc(mode, idIdx);
              if (mode == MD_IDRD && idIdx != 2'd3) idxN = idIdx + 2'd1;
              cntN   = 4'd1;
              stateN = ST_TXB;
            end else begin
              stateN = ST_SKIP;
            end
          end
        end
        default: stateN = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      mode    <= MD_ADDR;
      bitCnt  <= '0;
      idArmed <= 1'b0;
      idIdx   <= '0;
      mAck    <= 1'b0;
    end else begin
      state   <= stateN;
      mode    <= modeN;
      bitCnt  <= cntN;
      idArmed <= armN;
      idIdx   <= idxN;
      mAck    <= mAckN;
    end
  end

  assert_one_drive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.txLoad, stb.txBit, stb.ackDrv}));

  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopEv |=> state == ST_IDLE);

endmodule

// File: rtl/chan_select_switch.sv
module chan_select_switch
  import chan_select_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int FILT_LEN = 3,
  parameter logic [2:0] ADDR_BASE = 3'b101,
  parameter logic [7:0] ID_BYTE0  = 8'h3C,
  parameter logic [7:0] ID_BYTE1  = 8'h51,
  parameter logic [7:0] ID_BYTE2  = 8'h07
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              hwRstN,
  input  logic [1:0]        strapLo,
  input  logic [1:0]        strapHi,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [NUM_CH-1:0] chanEn
);

  logic       rstAllN;
  logic [6:0] ownAddr;
  logic [7:0] rxByte;
  strobe_t    stb;
  busEv_t     ev;

  assign rstAllN = porRstN & hwRstN;
  assign ownAddr = {ADDR_BASE, strapHi, strapLo};

  chan_select_dp #(
    .NUM_CH(NUM_CH), .FILT_LEN(FILT_LEN),
    .ID_BYTE0(ID_BYTE0), .ID_BYTE1(ID_BYTE1), .ID_BYTE2(ID_BYTE2)
  ) u_dp (
    .clk(clk), .rstN(rstAllN), .sclIn(sclIn), .sdaIn(sdaIn),
    .stb(stb), .ev(ev), .rxByte(rxByte), .sdaOe(sdaOe), .chanEn(chanEn)
  );

  chan_select_fsm u_fsm (
    .clk(clk), .rstN(rstAllN), .ev(ev), .rxByte(rxByte),
    .ownAddr(ownAddr), .stb(stb)
  );

  assert_hw_clear_R4: assert property (@(posedge clk) disable iff (!porRstN)
    !hwRstN |-> (chanEn == '0 && !sdaOe));

endmodule

// File: tb/chan_select_switch_test.sv
module chan_select_switch_test;

  localparam int CLK_PERIOD = 10;
  localparam int QTR = 10;

  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       hwRstN = 1'b0;
  logic [1:0] strapLo = 2'd2;
  logic [1:0] strapHi = 2'd1;
  logic       sclDrv = 1'b1;
  logic       sdaDrv = 1'b1;
  logic       sdaLine;
  logic       sdaOe;
  logic [3:0] chanEn;

  int total = 0;
  int bad = 0;

  assign sdaLine = sdaDrv & ~sdaOe;

  chan_select_switch uut (
    .clk(clk), .porRstN(porRstN), .hwRstN(hwRstN),
    .strapLo(strapLo), .strapHi(strapHi),
    .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe), .chanEn(chanEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ(); waitQ();
  endtask

  task automatic bitW(input logic b);
    sdaDrv = b; waitQ();
    sclDrv = 1'b1; waitQ(); waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic bitR(output logic v);
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    v = sdaLine; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic byteW(input logic [7:0] d, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) bitW(d[i]);
    bitR(v);
    ack = ~v;
  endtask

  task automatic byteR(input logic ackIt, output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bitR(v);
      d[i] = v;
    end
    bitW(~ackIt);
  endtask

  function automatic logic [6:0] addrOf(input logic [3:0] s);
    return {3'b101, s[3:2], s[1:0]};
  endfunction

  task automatic regWrite(input logic [6:0] a, input logic [7:0] d, input string tag);
    logic ack;
    busStart();
    byteW({a, 1'b0}, ack); check({tag, " addr ack"}, ack, 1);
    byteW(d, ack);         check({tag, " data ack"}, ack, 1);
    busStop();
  endtask

  task automatic regRead(input logic [6:0] a, output logic [7:0] d, input string tag);
    logic ack;
    busStart();
    byteW({a, 1'b1}, ack); check({tag, " rd addr ack"}, ack, 1);
    byteR(1'b0, d);
    busStop();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [6:0] own;
    logic [7:0] rd;
    logic       ack;
    logic       seen;

    // R5: power-on state
    repeat (5) @(negedge clk);
    check("R5 en in reset", chanEn, 0);
    check("R9 sdaOe in reset", sdaOe, 0);
    hwRstN = 1'b1;
    @(negedge clk);
    porRstN = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (chanEn != 0 || sdaOe) seen = 1'b1;
    end
    check("R5 no pulse after reset", seen, 0);

    own = addrOf({strapHi, strapLo});

    // R1 R2 R3: every enable pattern, with junk in the upper nibble
    for (int p = 0; p < 16; p++) begin
      logic [3:0] prev;
      prev = chanEn;
      busStart();
      byteW({own, 1'b0}, ack); check("R6 own addr ack", ack, 1);
      byteW({4'(p * 7 + 3), 4'(p)}, ack); check("R1 data ack", ack, 1);
      check("R2 held until stop", chanEn, prev);
      busStop();
      check("R1 enable pattern", chanEn, p);
      check("R9 idle release", sdaOe, 0);
      regRead(own, rd, "R3");
      check("R3 readback", rd, p);
    end

    // R2: several data bytes, last one wins
    busStart();
    byteW({own, 1'b0}, ack);
    byteW(8'h01, ack);
    byteW(8'h02, ack);
    busStop();
    check("R2 last byte wins", chanEn, 2);

    // R2: repeated START aborts the pending write
    busStart();
    byteW({own, 1'b0}, ack);
    byteW(8'h0D, ack);
    busStart();
    byteW(8'h22, ack); check("R6 foreign nack", ack, 0);
    busStop();
    check("R2 abort keeps enables", chanEn, 2);

    // R10: one-clock SDA pulse while SCL high is not a STOP
    busStart();
    byteW({own, 1'b0}, ack);
    byteW(8'h09, ack);
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    @(negedge clk) sdaDrv = 1'b1;
    @(negedge clk) sdaDrv = 1'b0;
    waitQ(); waitQ();
    check("R10 glitch not stop", chanEn, 2);
    sclDrv = 1'b0; waitQ();
    busStart();
    byteW(8'h22, ack);
    busStop();
    check("R10 pending dropped", chanEn, 2);

    // R7: general call
    regWrite(own, 8'h0B, "R7 setup");
    busStart();
    byteW(8'h00, ack); check("R7 gc addr ack", ack, 1);
    byteW(8'h05, ack); check("R7 other cmd nack", ack, 0);
    busStop();
    check("R7 other cmd no effect", chanEn, 4'hB);
    busStart();
    byteW(8'h00, ack); check("R7 gc addr ack", ack, 1);
    byteW(8'h06, ack); check("R7 reset cmd ack", ack, 1);
    check("R7 cleared before stop", chanEn, 0);
    busStop();
    check("R7 cleared", chanEn, 0);

    // R8: identification query
    busStart();
    byteW(8'hF8, ack); check("R8 query ack", ack, 1);
    byteW({own, 1'b0}, ack); check("R8 arg ack", ack, 1);
    busStart();
    byteW(8'hF9, ack); check("R8 read ack", ack, 1);
    byteR(1'b1, rd); check("R8 id byte0", rd, 8'h3C);
    byteR(1'b1, rd); check("R8 id byte1", rd, 8'h51);
    byteR(1'b1, rd); check("R8 id byte2", rd, 8'h07);
    byteR(1'b0, rd); check("R8 fill byte", rd, 8'hFF);
    busStop();
    busStart();
    byteW(8'hF8, ack);
    byteW({own ^ 7'h01, 1'b0}, ack); check("R8 wrong arg nack", ack, 0);
    busStart();
    byteW(8'hF9, ack); check("R8 unarmed nack", ack, 0);
    busStop();
    check("R9 released after nack", sdaOe, 0);

    // R4: reset in the middle of a data byte
    regWrite(own, 8'h0F, "R4 setup");
    busStart();
    byteW({own, 1'b0}, ack);
    for (int i = 0; i < 4; i++) bitW(1'b0);
    hwRstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 en cleared mid byte", chanEn, 0);
    check("R4 sda released", sdaOe, 0);
    sclDrv = 1'b1; sdaDrv = 1'b1;
    repeat (10) @(negedge clk);
    hwRstN = 1'b1;
    repeat (20) @(negedge clk);
    check("R4 still clear", chanEn, 0);
    regWrite(own, 8'h06, "R4 recover");
    check("R4 recover write", chanEn, 6);

    // R4 R9: reset while the block drives ACK
    busStart();
    for (int i = 7; i >= 0; i--) bitW(own[i > 0 ? i - 1 : 0] & (i > 0));
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    check("R9 ack drives low", sdaOe, 1);
    hwRstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 ack released", sdaOe, 0);
    check("R4 en cleared in ack", chanEn, 0);
    repeat (10) @(negedge clk);
    hwRstN = 1'b1;
    repeat (20) @(negedge clk);

    // R6: all sixteen strap codes
    for (int s = 0; s < 16; s++) begin
      logic [3:0] sv;
      sv = 4'(s);
      strapLo = sv[1:0];
      strapHi = sv[3:2];
      repeat (4) @(negedge clk);
      own = addrOf(sv);
      regWrite(own, {4'h0, sv ^ 4'h5}, "R6 sweep");
      regRead(own, rd, "R6 sweep");
      check("R6 strap readback", rd, {4'h0, sv ^ 4'h5});
      busStart();
      byteW({own ^ 7'h04, 1'b0}, ack); check("R6 neighbour nack", ack, 0);
      busStop();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule